// File: doc/BRIEF.md
# Pulse-Swallow Integer-N Divider Controller

This block divides a fast input clock by a programmable integer to produce one short pulse per division cycle, as the feedback divider of a frequency synthesizer. It models the prescaler as a period counter whose modulus is either N+1 or N, and it pairs that with a swallow counter and a 7-bit program counter that both step once per prescaler period. The base ratio N is 32 in the low band and 47 in the high band, so each division cycle spans N*P + S input clocks: S prescaler periods at the larger modulus and P-S periods at the smaller one.

The top bit of the program counter is hard-wired high rather than taken from the programmed word, so only the six lower bits of P are supplied; together with the band-dependent prescaler ratio this lets one 7-bit counter serve both the low band (P from 75 to 78) and the high band (P from 105 to 122). When the program counter runs out, a load strobe reloads every counter from the inputs, clears the modulus control back to the larger ratio, and emits the divided output pulse. Configuration inputs are sampled only at that strobe or during reset, so they may be changed at any time without disturbing a cycle in progress. A swallow value beyond the band's limit is clamped and reported.

Top module: `pswal_divider`

## Requirements
- R1: Successive division cycles each last exactly N*P + S input clock cycles, with N = 32 when band_hi = 0 and N = 47 when band_hi = 1.
- R2: The effective program value is P = 64 + p_low, the counter's top bit being tied to 1 regardless of any input; this covers the low-band values 75 to 78 and the high-band values 105 to 122.
- R3: div_out is high for exactly one input clock cycle, the last cycle of each division cycle, and low in every other cycle.
- R4: Within a division cycle, mod_ctl is 0 for the first S*(N+1) input cycles (larger modulus) and 1 for the remaining N*(P-S) cycles (smaller modulus).
- R5: Once mod_ctl is 1, the swallow counter holds its value without stepping until the next load strobe, so mod_ctl stays 1 until the cycle boundary.
- R6: band_hi, p_low and s_val are sampled only at the clock edge that ends a division cycle or while rst is high; changes at any other time affect nothing until the next division cycle starts.
- R7: If the sampled s_val exceeds the band limit (31 for band_hi = 0, 47 for band_hi = 1), S is clamped to that limit and cfg_err is 1 for that whole division cycle; otherwise cfg_err is 0.
- R8: rst is synchronous and active high; while it is high div_out is 0 and the configuration is loaded, and the first division cycle starts on the first clock edge with rst low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| band_hi | input | 1 | Band select: 0 gives N = 32, 1 gives N = 47 |
| p_low | input | 6 | Lower six bits of the program value P |
| s_val | input | 6 | Swallow count S |
| div_out | output | 1 | One-cycle pulse at the end of each division cycle |
| mod_ctl | output | 1 | Modulus control: 0 while the larger ratio is used, 1 for the smaller |
| cfg_err | output | 1 | Swallow value was clamped for the current division cycle |

## Verification
All three outputs are decoded from registered counter state, so each is due in the same cycle as the counter state it reflects: div_out in the final cycle of a division cycle, mod_ctl from the cycle after S*(N+1) inputs have passed, and new configuration values from the first cycle after the strobe edge that samples them. The bench keeps a cycle counter and a computed cycle length for the current division cycle, updates them at each rising edge exactly as the requirements state, and compares every output at the following falling edge. Configuration changes are applied mid-cycle, and reset is reapplied mid-cycle, to check that sampling happens only at the boundary.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

    // Widths of the counters and programmed fields
    localparam int P_W   = 7;
    localparam int S_W   = 6;
    localparam int PL_W  = P_W - 1;
    localparam int PRE_W = 6;

    typedef enum logic {
        BAND_LO = 1'b0,
        BAND_HI = 1'b1
    } band_e;

    // Configuration taken at a division-cycle boundary
    typedef struct packed {
        band_e            band;
        logic [P_W-1:0]   p_val;
        logic [S_W-1:0]   s_val;
        logic             s_over;
    } cfg_t;

    // Base prescaler ratio for a band
    function automatic int base_ratio(band_e b, int n_lo, int n_hi);
        return (b == BAND_HI) ? n_hi : n_lo;
    endfunction

    // Largest swallow count permitted in a band
    function automatic logic [S_W-1:0] swallow_limit(band_e b, int lim_lo, int lim_hi);
        return (b == BAND_HI) ? S_W'(lim_hi) : S_W'(lim_lo);
    endfunction

    // Reload value of the prescaler period counter (period length minus one)
    function automatic logic [PRE_W-1:0] period_reload(band_e b, logic swallowing,
                                                       int n_lo, int n_hi);
        int len;
        len = base_ratio(b, n_lo, n_hi) + (swallowing ? 1 : 0);
        return PRE_W'(len - 1);
    endfunction

endpackage

// File: rtl/pswal_cfg.sv
module pswal_cfg
    import pswal_pkg::*;
#(
    parameter int S_LIM_LO = 31,
    parameter int S_LIM_HI = 47
) (
    input  logic              clk,
    input  logic              load,
    input  logic              band_in,
    input  logic [PL_W-1:0]   p_low,
    input  logic [S_W-1:0]    s_in,
    output cfg_t              ld_cfg,
    output band_e             band_q,
    output logic              err_q
);

    logic [S_W-1:0] lim;

    always_comb begin
        ld_cfg.band   = band_e'(band_in);
        ld_cfg.p_val  = {1'b1, p_low};
        lim           = swallow_limit(ld_cfg.band, S_LIM_LO, S_LIM_HI);
        ld_cfg.s_over = (s_in > lim);
        ld_cfg.s_val  = ld_cfg.s_over ? lim : s_in;
    end

    // Only the band and the error flag are needed after a load
    always_ff @(posedge clk) begin
        if (load) begin
            band_q <= ld_cfg.band;
            err_q  <= ld_cfg.s_over;
        end
    end

endmodule

// File: rtl/pswal_prescaler.sv
module pswal_prescaler
    import pswal_pkg::*;
#(
    parameter int N_LO = 32,
    parameter int N_HI = 47
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  band_e  ld_band,
    input  logic   ld_swallow,
    input  band_e  band_q,
    input  logic   more_swallow,
    output logic   period_end
);

    logic [PRE_W-1:0] pre_cnt;

    assign period_end = (pre_cnt == '0);

    always_ff @(posedge clk) begin
        if (load) begin
            pre_cnt <= period_reload(ld_band, ld_swallow, N_LO, N_HI);
        end else if (period_end) begin
            pre_cnt <= period_reload(band_q, more_swallow, N_LO, N_HI);
        end else begin
            pre_cnt <= pre_cnt - 1'b1;
        end
    end

    // A new period never lasts fewer than N_LO input cycles
    assert_period_len_R4: assert property (@(posedge clk) disable iff (rst)
        period_end |=> (pre_cnt >= PRE_W'(N_LO - 1)));

endmodule

// File: rtl/pswal_swallow.sv
module pswal_swallow
    import pswal_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [S_W-1:0]  ld_s,
    input  logic            period_end,
    output logic            mod_ctl,
    output logic            more_swallow
);

    logic [S_W-1:0] scnt;

    assign mod_ctl      = (scnt == '0);
    assign more_swallow = (scnt > S_W'(1));

    always_ff @(posedge clk) begin
        if (load) begin
            scnt <= ld_s;
        end else if (period_end && !mod_ctl) begin
            scnt <= scnt - 1'b1;
        end
    end

    // The counter stays idle once swallowing is over
    assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (mod_ctl && !load) |=> $stable(scnt));

endmodule

// File: rtl/pswal_progctr.sv
module pswal_progctr
    import pswal_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [P_W-1:0]  ld_p,
    input  logic            period_end,
    output logic            at_zero
);

    logic [P_W-1:0] pcnt;

    assign at_zero = (pcnt == '0);

    always_ff @(posedge clk) begin
        if (load) begin
            pcnt <= ld_p - 1'b1;
        end else if (period_end) begin
            pcnt <= pcnt - 1'b1;
        end
    end

    // Counting only moves downward between loads
    assert_down_R1: assert property (@(posedge clk) disable iff (rst)
        (!load && period_end) |=> (pcnt < $past(pcnt)));

endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
    import pswal_pkg::*;
#(
    parameter int N_LO     = 32,
    parameter int N_HI     = 47,
    parameter int S_LIM_LO = 31,
    parameter int S_LIM_HI = 47
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             band_hi,
    input  logic [PL_W-1:0]  p_low,
    input  logic [S_W-1:0]   s_val,
    output logic             div_out,
    output logic             mod_ctl,
    output logic             cfg_err
);

    cfg_t   ld_cfg;
    band_e  band_q;
    logic   period_end;
    logic   at_zero;
    logic   more_swallow;
    logic   strobe;
    logic   load;

    assign strobe  = period_end & at_zero;
    assign load    = rst | strobe;
    assign div_out = strobe;

    pswal_cfg #(
        .S_LIM_LO (S_LIM_LO),
        .S_LIM_HI (S_LIM_HI)
    ) u_cfg (
        .clk     (clk),
        .load    (load),
        .band_in (band_hi),
        .p_low   (p_low),
        .s_in    (s_val),
        .ld_cfg  (ld_cfg),
        .band_q  (band_q),
        .err_q   (cfg_err)
    );

    pswal_prescaler #(
        .N_LO (N_LO),
        .N_HI (N_HI)
    ) u_pre (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .ld_band      (ld_cfg.band),
        .ld_swallow   (ld_cfg.s_val != '0),
        .band_q       (band_q),
        .more_swallow (more_swallow),
        .period_end   (period_end)
    );

    pswal_swallow u_swl (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .ld_s         (ld_cfg.s_val),
        .period_end   (period_end),
        .mod_ctl      (mod_ctl),
        .more_swallow (more_swallow)
    );

    pswal_progctr u_prg (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .ld_p       (ld_cfg.p_val),
        .period_end (period_end),
        .at_zero    (at_zero)
    );

    // Output pulse is a single cycle wide
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    // A boundary restores the larger modulus unless S is zero
    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        div_out |=> (mod_ctl == ($past(ld_cfg.s_val) == '0)));

    // Outputs are low during reset after the first edge
    assert_reset_quiet_R8: assert property (@(posedge clk)
        $past(rst) |-> !div_out);

endmodule

// File: tb/pswal_divider_test.sv
module pswal_divider_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       band_hi = 1'b0;
    logic [5:0] p_low = 6'd11;
    logic [5:0] s_val = 6'd10;
    logic       div_out, mod_ctl, cfg_err;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    done   = 1'b0;
    string phase  = "R8 reset";

    // Reference state
    int m_cnt = 0;
    int m_tot = 1;
    int m_sw  = 0;
    bit m_err = 1'b0;

    always #2 clk = ~clk;

    pswal_divider uut (
        .clk     (clk),
        .rst     (rst),
        .band_hi (band_hi),
        .p_low   (p_low),
        .s_val   (s_val),
        .div_out (div_out),
        .mod_ctl (mod_ctl),
        .cfg_err (cfg_err)
    );

    always @(posedge clk) begin
        int n, lim, s;
        if (rst || m_cnt == m_tot - 1) begin
            n     = band_hi ? 47 : 32;
            lim   = band_hi ? 47 : 31;
            s     = (int'(s_val) > lim) ? lim : int'(s_val);
            m_err = (int'(s_val) > lim);
            m_tot = n * (64 + int'(p_low)) + s;
            m_sw  = s * (n + 1);
            m_cnt = 0;
        end else begin
            m_cnt = m_cnt + 1;
        end
    end

    task automatic cmp(string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t actual=%b expected=%b", what, phase, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            cmp("div_out R1,R2,R3", div_out, !rst && (m_cnt == m_tot - 1));
            cmp("mod_ctl R4,R5",    mod_ctl, m_cnt >= m_sw);
            cmp("cfg_err R7",       cfg_err, m_err);
        end
    end

    task automatic run(int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        // R8: reset held, low band P=75 S=10
        run(5);
        rst = 1'b0;
        phase = "R1 R4 low band P=75 S=10";
        run(7300);

        // R6: change everything mid-cycle, high band P=122 S=47
        phase = "R6 deferred change to P=122 S=47";
        run(100);
        band_hi = 1'b1; p_low = 6'd58; s_val = 6'd47;
        run(14000);

        // R4: zero swallow, high band P=105
        phase = "R4 S=0 P=105";
        p_low = 6'd41; s_val = 6'd0;
        run(10000);

        // R7: low band overrange S=40 clamps to 31, P=78
        phase = "R7 low band clamp";
        band_hi = 1'b0; p_low = 6'd14; s_val = 6'd40;
        run(6000);

        // R7/R2: high band S=63 clamps to 47, P=127
        phase = "R7 R2 high band clamp P=127";
        band_hi = 1'b1; p_low = 6'd63; s_val = 6'd63;
        run(12500);

        // R8: reset mid-cycle, then low band P=76 S=31
        phase = "R8 reset mid-cycle";
        band_hi = 1'b0; p_low = 6'd12; s_val = 6'd31;
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        run(5000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog [%s] actual=running expected=finished", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule